// File: doc/BRIEF.md
# Token-Bucket Request Rate Regulator

This block sits on the address-request path of one bus master and decides, cycle by cycle, whether a request may pass toward the interconnect. It keeps a token bucket whose depth sets how many requests may go out back to back. Tokens return at an average rate selected by a level code, and each level halves the rate. A second, faster peak rate enforces a minimum gap between two accepted requests, even when tokens are still in the bucket.

The master-side valid/ready pair enters on `up_*` and leaves as a gated pair on `dn_*`. Configuration comes in as plain fields: an on bit, the bucket depth minus one, and two level codes from 0 to 11. A level L gives a rate of one event every 2^(L+1) cycles. When the block is switched off, requests pass straight through and the bucket is held full. The configuration is valid only when the peak level is strictly lower than the average level.

Top module: `req_token_gate`

## Requirements
- R1: After reset the bucket holds its full depth and both rate counters are zero. With depth 3, average level 11 and peak level 0, the first three requests go out at cycles 0, 2 and 4, and no further request passes for the rest of a 20-cycle window.
- R2: Each handshake (`dn_valid` and `dn_ready` both high) uses one token. While the bucket is empty, `up_ready` and `dn_valid` stay low.
- R3: With the block on, one token is added every 2^(A+1) cycles, where A is the average level. The first addition happens in cycle 2^(A+1)-1 counted from the first enabled cycle.
- R4: The bucket depth equals `burst_m1` + 1, so it ranges from 1 to 256. Refill never raises the count above this depth.
- R5: When a token is added in the same cycle that a handshake uses one, the count stays unchanged.
- R6: After a handshake, the next one is held off until 2^(P+1) cycles have passed, where P is the peak level, even if tokens remain.
- R7: While `reg_on` is low, `dn_valid` follows `up_valid`, `up_ready` follows `dn_ready`, and the bucket is refilled to its depth with both counters cleared. A full burst is therefore available again when the block is switched back on.
- R8: `dn_valid` and `up_ready` are opened together, so a handshake on one side always coincides with a handshake on the other. A request held while `dn_ready` is low uses no token.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_on | input | 1 | Regulator on; when low, requests bypass the regulator |
| burst_m1 | input | 8 | Bucket depth minus one |
| peak_lvl | input | 4 | Peak level, minimum gap of 2^(P+1) cycles between handshakes |
| avg_lvl | input | 4 | Average level, one token every 2^(A+1) cycles |
| up_valid | input | 1 | Request valid from the master |
| up_ready | output | 1 | Ready back to the master |
| dn_valid | output | 1 | Gated request valid toward the interconnect |
| dn_ready | input | 1 | Ready from the interconnect |

## Verification
The bound checker watches, on every cycle, the properties that can be seen at each edge:
- no handshake happens with an empty bucket;
- the token count never goes above the programmed depth;
- two handshakes are never adjacent while the block is on;
- the bypass holds while the block is off;
- the two sides of the handshake agree.

Rates, burst lengths, the saturation of refill and the case where a refill and a consumption land in the same cycle only show up as handshake counts over a window. The bench scenarios count handshakes over a fixed window from a known starting phase and compare them with values worked out by hand.

// File: rtl/req_token_gate.sv
module req_token_gate #(
  parameter int BURST_W = 8,
  parameter int LVL_W   = 4,
  parameter int MAX_LVL = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_on,
  input  logic [BURST_W-1:0] burst_m1,
  input  logic [LVL_W-1:0]   peak_lvl,
  input  logic [LVL_W-1:0]   avg_lvl,
  input  logic               up_valid,
  output logic               up_ready,
  output logic               dn_valid,
  input  logic               dn_ready
);
  localparam int TOK_W = BURST_W + 1;
  localparam int CNT_W = MAX_LVL + 1;
  localparam logic [TOK_W-1:0] TOK_MAX = TOK_W'(1) << BURST_W;

  function automatic logic [CNT_W-1:0] lvl_mask(input logic [LVL_W-1:0] lvl);
    logic [CNT_W-1:0] m;
    for (int i = 0; i < CNT_W; i++) m[i] = (i <= int'(lvl));
    return m;
  endfunction

  logic [TOK_W-1:0] tok_q, depth, base, tok_d;
  logic [CNT_W-1:0] avg_cnt, gap_cnt, avg_mask, pk_mask;
  logic [LVL_W-1:0] avg_l, pk_l;
  logic tick, open, acc, add;

  assign avg_l    = (int'(avg_lvl) > MAX_LVL) ? LVL_W'(MAX_LVL) : avg_lvl;
  assign pk_l     = (int'(peak_lvl) > MAX_LVL) ? LVL_W'(MAX_LVL) : peak_lvl;
  assign avg_mask = lvl_mask(avg_l);
  assign pk_mask  = lvl_mask(pk_l);

  assign depth = {1'b0, burst_m1} + TOK_W'(1);
  assign base  = (tok_q > depth) ? depth : tok_q;
  assign tick  = (avg_cnt == avg_mask);
  assign add   = tick && (base < depth);
  assign open  = !reg_on || ((tok_q != '0) && (gap_cnt == '0));
  assign acc   = reg_on && open && up_valid && dn_ready;
  assign tok_d = base + TOK_W'(add) - TOK_W'(acc);

  assign dn_valid = up_valid && open;
  assign up_ready = dn_ready && open;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tok_q   <= TOK_MAX;
      avg_cnt <= '0;
      gap_cnt <= '0;
    end else if (!reg_on) begin
      tok_q   <= depth;
      avg_cnt <= '0;
      gap_cnt <= '0;
    end else begin
      tok_q   <= tok_d;
      avg_cnt <= tick ? '0 : avg_cnt + CNT_W'(1);
      if (acc)                 gap_cnt <= pk_mask;
      else if (gap_cnt != '0)  gap_cnt <= gap_cnt - CNT_W'(1);
    end
  end
endmodule

module req_token_gate_chk #(
  parameter int BURST_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_on,
  input logic [BURST_W-1:0] burst_m1,
  input logic               up_valid,
  input logic               up_ready,
  input logic               dn_valid,
  input logic               dn_ready,
  input logic [BURST_W:0]   tokens
);
  logic warm;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) warm <= 1'b0;
    else        warm <= 1'b1;

  assert_no_take_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_on && dn_valid && dn_ready) |-> (tokens != '0));

  assert_depth_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $stable(burst_m1) && $past(reg_on)) |-> (tokens <= {1'b0, burst_m1} + 1'b1));

  assert_peak_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_on && dn_valid && dn_ready) |=> !(reg_on && dn_valid && dn_ready));

  assert_bypass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_on |-> ((dn_valid == up_valid) && (up_ready == dn_ready)));

  assert_handshake_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && dn_ready) |-> (up_valid && up_ready));
endmodule

bind req_token_gate req_token_gate_chk #(.BURST_W(BURST_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_on(reg_on), .burst_m1(burst_m1),
  .up_valid(up_valid), .up_ready(up_ready), .dn_valid(dn_valid),
  .dn_ready(dn_ready), .tokens(tok_q)
);

// File: tb/tb_req_token_gate.sv
`timescale 1ns/1ps
module tb_req_token_gate;
  logic clk = 1'b0, rst_n = 1'b0, reg_on = 1'b0;
  logic [7:0] burst_m1 = '0;
  logic [3:0] peak_lvl = '0, avg_lvl = '0;
  logic up_valid = 1'b0, dn_ready = 1'b0;
  logic up_ready, dn_valid;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  req_token_gate dut (.clk(clk), .rst_n(rst_n), .reg_on(reg_on), .burst_m1(burst_m1),
    .peak_lvl(peak_lvl), .avg_lvl(avg_lvl), .up_valid(up_valid), .up_ready(up_ready),
    .dn_valid(dn_valid), .dn_ready(dn_ready));

  typedef struct packed {
    logic [7:0] req;
    logic       en;
    logic [7:0] bm1;
    logic [3:0] pk;
    logic [3:0] av;
    logic [7:0] k;
    logic [7:0] vdly;
    logic [7:0] rdly;
    logic [7:0] exp;
  } vec_t;

  localparam vec_t TBL [9] = '{
    '{8'd3, 1'b1, 8'd0,   4'd0, 4'd1,  8'd16, 8'd0,  8'd0,  8'd4},  // R3 depth 1, token every 4
    '{8'd2, 1'b1, 8'd3,   4'd0, 4'd2,  8'd16, 8'd0,  8'd0,  8'd5},  // R2 burst of 4 then refill
    '{8'd6, 1'b1, 8'd7,   4'd1, 4'd3,  8'd32, 8'd0,  8'd0,  8'd8},  // R6 gap 4 with refill
    '{8'd7, 1'b0, 8'd0,   4'd0, 4'd1,  8'd16, 8'd0,  8'd0,  8'd16}, // R7 bypass passes all
    '{8'd6, 1'b1, 8'd255, 4'd2, 4'd5,  8'd40, 8'd0,  8'd0,  8'd5},  // R6 gap 8, deep bucket
    '{8'd5, 1'b1, 8'd2,   4'd0, 4'd1,  8'd16, 8'd1,  8'd0,  8'd6},  // R5 tick and take together
    '{8'd8, 1'b1, 8'd0,   4'd0, 4'd1,  8'd12, 8'd0,  8'd10, 8'd1},  // R8 stall uses no token
    '{8'd4, 1'b1, 8'd1,   4'd0, 4'd3,  8'd76, 8'd64, 8'd0,  8'd2},  // R4 idle refill capped
    '{8'd7, 1'b1, 8'd2,   4'd0, 4'd11, 8'd20, 8'd0,  8'd0,  8'd3}   // R7 re-enable gives full burst
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run(input vec_t v, input bit init, output int n, output bit hs_bad);
    n = 0; hs_bad = 0;
    if (init) begin
      @(negedge clk);
      reg_on = 1'b0; up_valid = 1'b0; dn_ready = 1'b0;
      burst_m1 = v.bm1; peak_lvl = v.pk; avg_lvl = v.av;
    end
    for (int c = 0; c < int'(v.k); c++) begin
      @(negedge clk);
      reg_on = v.en;
      up_valid = (c >= int'(v.vdly));
      dn_ready = (c >= int'(v.rdly));
      #1;
      if (dn_valid && dn_ready) n++;
      if ((dn_valid && dn_ready) != (up_valid && up_ready)) hs_bad = 1;
    end
    @(negedge clk);
    up_valid = 1'b0; dn_ready = 1'b0;
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    bit bad;
    vec_t v;
    reg_on = 1'b1; burst_m1 = 8'd2; peak_lvl = 4'd0; avg_lvl = 4'd11;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset leaves bucket full and counters at zero
    v = '{8'd1, 1'b1, 8'd2, 4'd0, 4'd11, 8'd20, 8'd0, 8'd0, 8'd3};
    run(v, 1'b0, n, bad);
    check(n == 3, "R1 reset burst", n, 3);

    // R2: empty bucket closes both sides
    @(negedge clk);
    up_valid = 1'b1; dn_ready = 1'b1; #1;
    check(!up_ready, "R2 up_ready when empty", up_ready, 0);
    check(!dn_valid, "R2 dn_valid when empty", dn_valid, 0);

    // R7: bypass while off
    @(negedge clk);
    reg_on = 1'b0; up_valid = 1'b1; dn_ready = 1'b0; #1;
    check(dn_valid && !up_ready, "R7 bypass valid", {dn_valid, up_ready}, 2);
    @(negedge clk);
    up_valid = 1'b0; dn_ready = 1'b1; #1;
    check(!dn_valid && up_ready, "R7 bypass ready", {dn_valid, up_ready}, 1);

    foreach (TBL[i]) begin
      run(TBL[i], 1'b1, n, bad);
      check(n == int'(TBL[i].exp), $sformatf("R%0d vector %0d count", TBL[i].req, i), n, TBL[i].exp);
      check(!bad, $sformatf("R8 vector %0d handshake agreement", i), bad, 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule